// File: doc/BRIEF.md
# Serial audio receiver

This block takes stereo PCM from a three-wire serial audio bus and turns it into 18-bit signed left/right sample pairs in the system clock domain. The bus has three lines: a bit clock, a word clock that marks which channel is on the wire, and serial data. The system clock samples all three lines through synchronisers. It must run at least four times faster than the bit clock. Data is taken on each rising edge of the bit clock, after synchronisation. The bus never places a bit-clock rising edge at the same instant as a word-clock transition.

A two-bit format select picks one of four framings. Two framings place the word against the end of the channel slot: a 16-bit word or an 18-bit word. One framing places the word at the start of the slot. The last is the I2S arrangement, which starts one bit late and uses the opposite channel polarity. A word is taken only after a word-clock transition has been seen, so a slot that was already in progress at reset is thrown away. A pair is offered only after a left word and then a right word are complete.

The output is a valid/ready stream. The serial bus cannot be paused, so there is no back-pressure towards it. While `pair_valid` is high and `pair_ready` is low, the offered pair is held without change. If a newer pair completes while the old one is still held, the newer pair replaces it. With `pair_ready` tied high, `pair_valid` is a one-cycle strobe.

Top module: `srx_receiver`

## Requirements
- R1: Format 00 (16-bit, end of slot): the last 16 bits before a word-clock transition form the word, MSB first. The left channel is sent while the word clock is high. The output is the 16-bit word followed by two zero LSBs.
- R2: Format 01 (18-bit, end of slot): the last 18 bits before a word-clock transition form the word. The left channel is sent while the word clock is high.
- R3: Format 10 (start of slot): the word is the 18 bits starting at the first bit-clock rise after a word-clock transition. The left channel is sent while the word clock is high. Later bits in the slot are ignored.
- R4: Format 11 (I2S): the MSB is taken on the second bit-clock rise after a word-clock transition. The left channel is sent while the word clock is low. Bits beyond 18 are ignored. Slots of only 16 bits (32 bit clocks per frame) carrying 16-bit words are accepted.
- R5: In formats 10 and 11, a 16-bit word followed by two zero bits is accepted. The bus value 0x7FFF appears as 0x1FFFC and 0x8000 as 0x20000 (two's complement, sign in bit 17).
- R6: In formats 00 and 01, bits that come earlier in the slot than the word have no effect on the output.
- R7: No pair is offered until a complete left word and then a complete right word have arrived. A slot that began before the first word-clock transition seen after reset is discarded.
- R8: With two synchroniser stages, `pair_valid` rises at the fourth system-clock rising edge after the bit-clock rise that ends the right word.
- R9: While `pair_valid` is high and `pair_ready` is low, `pair_left` and `pair_right` hold steady. A newer pair replaces the held one. After a transfer, `pair_valid` falls on the next edge unless a new pair loads on that edge.
- R10: While reset is low, `pair_valid` is low and both sample outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fmt_sel | input | 2 | Framing select: 00, 01, 10, 11 as in R1 to R4 |
| ser_bclk | input | 1 | Serial bit clock |
| ser_wclk | input | 1 | Serial word (channel) clock |
| ser_data | input | 1 | Serial data, MSB first |
| pair_valid | output | 1 | Sample pair offered |
| pair_ready | input | 1 | Consumer accepts the pair |
| pair_left | output | 18 | Left sample, two's complement |
| pair_right | output | 18 | Right sample, two's complement |

## Verification
The right word ends on a bit-clock rise. That rise passes two synchroniser flops, then the edge detector. The capture register takes the word on the next edge, and the output register loads on the edge after that. So `pair_valid` first shows high after the fourth system edge. The bench drives the bus at negative clock edges and checks the exact cycle. Counting from that negative edge, it expects `pair_valid` low at the third following negative edge, high with the expected data at the fourth, and low again at the fifth. For the framing tests, each pair is sent for three frames and checked after the third. Any pair delivered during the third frame was therefore framed wholly by the pattern under test.

// File: rtl/srx_pkg.sv
package srx_pkg;
  localparam int SAMPLE_W = 18;
  localparam int SHORT_W  = 16;
  localparam int CNT_W    = $clog2(SAMPLE_W + 1);

  typedef enum logic [1:0] {
    FMT_END16 = 2'b00,
    FMT_END18 = 2'b01,
    FMT_START = 2'b10,
    FMT_I2S   = 2'b11
  } fmt_e;

  // Left-align a word that was captured from the start of a slot.
  function automatic logic [SAMPLE_W-1:0] align_start(
    input logic [SAMPLE_W-1:0] sh,
    input logic [CNT_W-1:0]    cnt
  );
    logic [SAMPLE_W-1:0] r;
    if (cnt >= CNT_W'(SAMPLE_W)) r = sh;
    else r = sh << (CNT_W'(SAMPLE_W) - cnt);
    return r;
  endfunction
endpackage

// File: rtl/srx_bus_sync.sv
module srx_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ser_bclk,
  input  logic ser_wclk,
  input  logic ser_data,
  output logic bit_rise,
  output logic wclk_lvl,
  output logic data_lvl
);
  localparam int LANES = 3;
  localparam int L_BCLK = 2;
  localparam int L_WCLK = 1;
  localparam int L_DATA = 0;

  logic [LANES-1:0] raw;
  logic [LANES-1:0] chain [STAGES];
  logic             bclk_q;

  assign raw = {ser_bclk, ser_wclk, ser_data};

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) chain[g] <= '0;
        else        chain[g] <= raw;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) chain[g] <= '0;
        else        chain[g] <= chain[g-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bclk_q <= 1'b0;
    else        bclk_q <= chain[STAGES-1][L_BCLK];
  end

  assign bit_rise = chain[STAGES-1][L_BCLK] & ~bclk_q;
  assign wclk_lvl = chain[STAGES-1][L_WCLK];
  assign data_lvl = chain[STAGES-1][L_DATA];
endmodule

// File: rtl/srx_word_capture.sv
module srx_word_capture
  import srx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  fmt_e                fmt,
  input  logic                bit_rise,
  input  logic                wclk_lvl,
  input  logic                data_lvl,
  output logic                word_done,
  output logic                word_is_left,
  output logic [SAMPLE_W-1:0] word_data
);
  localparam int PAD_W = SAMPLE_W - SHORT_W;

  logic                wclk_h1;
  logic                half_prev;
  logic [1:0]          prime;
  logic                seen;
  logic [SAMPLE_W-1:0] sh;
  logic [CNT_W-1:0]    cnt;

  logic                is_i2s;
  logic                end_mode;
  logic                half_now;
  logic                boundary;
  logic                ended_left;
  logic [SAMPLE_W-1:0] assembled;

  always_comb begin
    is_i2s     = (fmt == FMT_I2S);
    end_mode   = (fmt == FMT_END16) || (fmt == FMT_END18);
    // I2S slots are judged against the word clock one bit late
    half_now   = is_i2s ? wclk_h1 : wclk_lvl;
    boundary   = prime[1] && (half_now != half_prev);
    ended_left = is_i2s ? ~half_prev : half_prev;
    case (fmt)
      FMT_END16: assembled = {sh[SHORT_W-1:0], {PAD_W{1'b0}}};
      FMT_END18: assembled = sh;
      default:   assembled = align_start(sh, cnt);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wclk_h1      <= 1'b0;
      half_prev    <= 1'b0;
      prime        <= '0;
      seen         <= 1'b0;
      sh           <= '0;
      cnt          <= '0;
      word_done    <= 1'b0;
      word_is_left <= 1'b0;
      word_data    <= '0;
    end else begin
      word_done <= 1'b0;
      if (bit_rise) begin
        wclk_h1   <= wclk_lvl;
        half_prev <= half_now;
        if (!prime[1]) prime <= prime + 2'd1;
        if (boundary) begin
          seen <= 1'b1;
          if (seen) begin
            word_done    <= 1'b1;
            word_is_left <= ended_left;
            word_data    <= assembled;
          end
          sh  <= {{(SAMPLE_W-1){1'b0}}, data_lvl};
          cnt <= CNT_W'(1);
        end else begin
          if (end_mode || (cnt < CNT_W'(SAMPLE_W)))
            sh <= {sh[SAMPLE_W-2:0], data_lvl};
          if (cnt < CNT_W'(SAMPLE_W))
            cnt <= cnt + CNT_W'(1);
        end
      end
    end
  end

  // R8
  done_after_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |-> $past(bit_rise));

  // R7
  done_needs_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |-> seen);
endmodule

// File: rtl/srx_pair_out.sv
module srx_pair_out
  import srx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                word_done,
  input  logic                word_is_left,
  input  logic [SAMPLE_W-1:0] word_data,
  input  logic                pair_ready,
  output logic                pair_valid,
  output logic [SAMPLE_W-1:0] pair_left,
  output logic [SAMPLE_W-1:0] pair_right
);
  logic                have_left;
  logic [SAMPLE_W-1:0] left_hold;
  logic                load;

  assign load = word_done && !word_is_left && have_left;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      have_left  <= 1'b0;
      left_hold  <= '0;
      pair_valid <= 1'b0;
      pair_left  <= '0;
      pair_right <= '0;
    end else begin
      if (word_done && word_is_left) begin
        left_hold <= word_data;
        have_left <= 1'b1;
      end
      if (load) begin
        pair_left  <= left_hold;
        pair_right <= word_data;
        pair_valid <= 1'b1;
        have_left  <= 1'b0;
      end else if (pair_valid && pair_ready) begin
        pair_valid <= 1'b0;
      end
    end
  end

  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid && !pair_ready && !load |=>
      pair_valid && $stable(pair_left) && $stable(pair_right));

  // R9
  drop_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid && pair_ready && !load |=> !pair_valid);

  // R7
  release_on_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pair_valid) |-> $past(word_done && !word_is_left));

  // R7
  lone_right_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_done && !word_is_left && !have_left |=>
      $stable(pair_left) && $stable(pair_right));
endmodule

// File: rtl/srx_receiver.sv
module srx_receiver
  import srx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          fmt_sel,
  input  logic                ser_bclk,
  input  logic                ser_wclk,
  input  logic                ser_data,
  output logic                pair_valid,
  input  logic                pair_ready,
  output logic [SAMPLE_W-1:0] pair_left,
  output logic [SAMPLE_W-1:0] pair_right
);
  logic                bit_rise;
  logic                wclk_lvl;
  logic                data_lvl;
  logic                word_done;
  logic                word_is_left;
  logic [SAMPLE_W-1:0] word_data;

  srx_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .ser_bclk (ser_bclk),
    .ser_wclk (ser_wclk),
    .ser_data (ser_data),
    .bit_rise (bit_rise),
    .wclk_lvl (wclk_lvl),
    .data_lvl (data_lvl)
  );

  srx_word_capture u_cap (
    .clk          (clk),
    .rst_n        (rst_n),
    .fmt          (fmt_e'(fmt_sel)),
    .bit_rise     (bit_rise),
    .wclk_lvl     (wclk_lvl),
    .data_lvl     (data_lvl),
    .word_done    (word_done),
    .word_is_left (word_is_left),
    .word_data    (word_data)
  );

  srx_pair_out u_pair (
    .clk          (clk),
    .rst_n        (rst_n),
    .word_done    (word_done),
    .word_is_left (word_is_left),
    .word_data    (word_data),
    .pair_ready   (pair_ready),
    .pair_valid   (pair_valid),
    .pair_left    (pair_left),
    .pair_right   (pair_right)
  );
endmodule

// File: tb/srx_receiver_test.sv
module srx_receiver_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  fmt_sel = 2'b00;
  logic        ser_bclk = 1'b0;
  logic        ser_wclk = 1'b0;
  logic        ser_data = 1'b0;
  logic        pair_ready = 1'b1;
  logic        pair_valid;
  logic [17:0] pair_left;
  logic [17:0] pair_right;

  int checks = 0;
  int errors = 0;
  int out_cnt = 0;
  logic [17:0] last_l = '0;
  logic [17:0] last_r = '0;
  logic [17:0] exp_l = '0;
  logic [17:0] exp_r = '0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  srx_receiver uut (
    .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel),
    .ser_bclk(ser_bclk), .ser_wclk(ser_wclk), .ser_data(ser_data),
    .pair_valid(pair_valid), .pair_ready(pair_ready),
    .pair_left(pair_left), .pair_right(pair_right)
  );

  always @(posedge clk) begin
    if (rst_n && pair_valid && pair_ready) begin
      out_cnt <= out_cnt + 1;
      last_l  <= pair_left;
      last_r  <= pair_right;
    end
  end

  // {fmt[44:43], slot bits[42:37], short word[36], left[35:18], right[17:0]}
  localparam logic [44:0] VEC [9] = '{
    {2'd0, 6'd16, 1'b1, 18'h1FFFC, 18'h20000},
    {2'd0, 6'd32, 1'b1, 18'h048D0, 18'h3FFFC},
    {2'd1, 6'd18, 1'b0, 18'h2A5A5, 18'h15A5A},
    {2'd1, 6'd32, 1'b0, 18'h1FFFF, 18'h20001},
    {2'd2, 6'd18, 1'b0, 18'h3C3C3, 18'h0F0F0},
    {2'd2, 6'd32, 1'b1, 18'h2468C, 18'h13570},
    {2'd3, 6'd16, 1'b1, 18'h1ABCC, 18'h35554},
    {2'd3, 6'd32, 1'b0, 18'h2B3C1, 18'h0C0DE},
    {2'd3, 6'd24, 1'b0, 18'h00001, 18'h3FFFF}
  };

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [17:0] act, input logic [17:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Bit of a slot; p is the position counted from the first word bit.
  function automatic logic gen_bit(input logic [1:0] m, input int n,
                                   input logic s16, input logic [17:0] w,
                                   input int i);
    int wl;
    int p;
    wl = s16 ? 16 : 18;
    case (m)
      2'd0: begin wl = 16; p = i - (n - 16); end
      2'd1: begin wl = 18; p = i - (n - 18); end
      2'd2: p = i;
      default: p = i - 1;
    endcase
    if (p < 0) return 1'b1;
    if (p < wl) return w[17-p];
    if (p < 18) return 1'b0;
    return 1'b1;
  endfunction

  task automatic drive_bit(input logic lr, input logic d, input bit probe);
    @(negedge clk);
    ser_bclk = 1'b0; ser_wclk = lr; ser_data = d;
    repeat (4) @(negedge clk);
    ser_bclk = 1'b1;
    if (probe) begin
      repeat (3) @(negedge clk);
      chk(pair_valid == 1'b0, "R8", "valid early", {17'd0, pair_valid}, 18'd0);
      @(negedge clk);
      chk(pair_valid == 1'b1, "R8", "valid on 4th edge", {17'd0, pair_valid}, 18'd1);
      chk(pair_left == exp_l, "R7", "left after pair", pair_left, exp_l);
      chk(pair_right == exp_r, "R7", "right after pair", pair_right, exp_r);
      @(negedge clk);
      chk(pair_valid == 1'b0, "R9", "strobe one cycle", {17'd0, pair_valid}, 18'd0);
    end else begin
      repeat (3) @(negedge clk);
    end
  endtask

  task automatic send_frame(input logic [1:0] m, input int n, input logic s16,
                            input logic [17:0] l, input logic [17:0] r);
    logic lev;
    logic [17:0] w;
    logic [17:0] pw;
    for (int h = 0; h < 2; h++) begin
      w   = (h == 0) ? l : r;
      pw  = (h == 0) ? r : l;
      lev = (m == 2'd3) ? logic'(h) : logic'(h == 0);
      for (int i = 0; i < n; i++) begin
        if (m == 2'd3 && i == 0) drive_bit(lev, gen_bit(m, n, s16, pw, n), 1'b0);
        else                     drive_bit(lev, gen_bit(m, n, s16, w, i), 1'b0);
      end
    end
  endtask

  function automatic string tag_of(input logic [1:0] m);
    case (m)
      2'd0: return "R1";
      2'd1: return "R2";
      2'd2: return "R3";
      default: return "R4";
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int base;
    // R10: reset state
    repeat (5) @(negedge clk);
    chk(pair_valid == 1'b0, "R10", "valid in reset", {17'd0, pair_valid}, 18'd0);
    chk(pair_left == 18'd0, "R10", "left in reset", pair_left, 18'd0);
    chk(pair_right == 18'd0, "R10", "right in reset", pair_right, 18'd0);
    rst_n = 1'b1;

    // R7: partial slot, then left, then right without closing edge
    fmt_sel = 2'd2;
    exp_l = 18'h2D2D3; exp_r = 18'h1E1E1;
    for (int i = 0; i < 5; i++) drive_bit(1'b0, 1'b1, 1'b0);
    for (int i = 0; i < 18; i++) drive_bit(1'b1, gen_bit(2'd2, 18, 1'b0, exp_l, i), 1'b0);
    for (int i = 0; i < 18; i++) drive_bit(1'b0, gen_bit(2'd2, 18, 1'b0, exp_r, i), 1'b0);
    chk(out_cnt == 0, "R7", "no pair before right ends", 18'(out_cnt), 18'd0);
    chk(pair_valid == 1'b0, "R7", "valid before right ends", {17'd0, pair_valid}, 18'd0);
    // R8: closing rise, exact cycle of the strobe
    drive_bit(1'b1, 1'b0, 1'b1);

    // Table walk: each pattern three frames, check pair from frame two
    for (int v = 0; v < 9; v++) begin
      logic [1:0]  m;
      int          n;
      logic        s16;
      logic [17:0] l;
      logic [17:0] r;
      m = VEC[v][44:43]; n = int'(VEC[v][42:37]); s16 = VEC[v][36];
      l = VEC[v][35:18]; r = VEC[v][17:0];
      fmt_sel = m;
      base = out_cnt;
      for (int f = 0; f < 3; f++) send_frame(m, n, s16, l, r);
      @(negedge clk);
      chk(out_cnt > base, tag_of(m), "pair delivered", 18'(out_cnt - base), 18'd1);
      chk(last_l == l, tag_of(m), "left sample", last_l, l);
      chk(last_r == r, tag_of(m), "right sample", last_r, r);
      if (s16 && m >= 2'd2) chk(last_l == l && last_r == r, "R5", "padded short word", last_l, l);
      if (m <= 2'd1 && n > 18) chk(last_r == r, "R6", "early slot bits ignored", last_r, r);
    end

    // R9: back-pressure hold and replacement
    fmt_sel = 2'd1;
    pair_ready = 1'b0;
    for (int f = 0; f < 3; f++) send_frame(2'd1, 18, 1'b0, 18'h11111, 18'h22222);
    chk(pair_valid == 1'b1, "R9", "valid held", {17'd0, pair_valid}, 18'd1);
    chk(pair_left == 18'h11111, "R9", "held left", pair_left, 18'h11111);
    repeat (6) @(negedge clk);
    chk(pair_right == 18'h22222, "R9", "held right stable", pair_right, 18'h22222);
    for (int f = 0; f < 3; f++) send_frame(2'd1, 18, 1'b0, 18'h33333, 18'h04444);
    chk(pair_left == 18'h33333, "R9", "newer left replaces", pair_left, 18'h33333);
    chk(pair_right == 18'h04444, "R9", "newer right replaces", pair_right, 18'h04444);
    base = out_cnt;
    @(negedge clk);
    pair_ready = 1'b1;
    @(negedge clk);
    pair_ready = 1'b0;
    chk(pair_valid == 1'b0, "R9", "valid drops after take", {17'd0, pair_valid}, 18'd0);
    chk(out_cnt == base + 1, "R9", "one transfer", 18'(out_cnt - base), 18'd1);

    // R10: reset while a pair is held
    for (int f = 0; f < 3; f++) send_frame(2'd1, 18, 1'b0, 18'h0ABCD, 18'h3DCBA);
    chk(pair_valid == 1'b1, "R10", "held before reset", {17'd0, pair_valid}, 18'd1);
    rst_n = 1'b0;
    @(negedge clk);
    chk(pair_valid == 1'b0, "R10", "valid cleared by reset", {17'd0, pair_valid}, 18'd0);
    chk(pair_left == 18'd0, "R10", "left cleared by reset", pair_left, 18'd0);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule